// File: doc/BRIEF.md
# Page-Crossing Instruction Fetch Translator

This block fetches one instruction of 16 or 32 bits from virtual memory. A fetch request carries a virtual address and a compressed-mode enable. The block checks alignment, asks a translation port for the physical address and reads the instruction from a memory port. It returns the instruction bits, or a fault cause together with the faulting virtual address.

In compressed mode the block translates and reads the low halfword first. It looks at that halfword to decide the instruction length. A 32-bit instruction then needs a second, independent translation of the address plus two. Because of this, a 32-bit instruction that straddles a page boundary is assembled from two different physical pages. With compressed mode off, one translation and one 32-bit read are enough.

The translation port and the memory port each use a level request that is held until a single-cycle response pulse arrives. The block has only one fetch in flight at a time.

Top module: `ifx_fetch`

## Requirements
- R1: While reset is asserted and after it is released, `done`, `xl_req` and `mem_req` are 0 and `fetch_ready` is 1.
- R2: A fetch is misaligned when compressed mode is on and address bit 0 is 1, or when compressed mode is off and either of address bits 1:0 is 1. A misaligned fetch completes with `fault_cause` = 1, `bad_vaddr` equal to the fetch address and `insn` = 0. It completes on the first edge after acceptance and issues no translation.
- R3: In compressed mode the first translation request uses the fetch address, and the memory read that follows is a halfword read (`mem_word` = 0) whose data sits in `mem_rdata[15:0]`.
- R4: In compressed mode, a low halfword whose bits 1:0 are not both 1 is a 16-bit instruction. Only one translation is made for it, and `insn` equals that halfword zero-extended to 32 bits.
- R5: In compressed mode, a low halfword with bits 1:0 equal to 3 triggers a second translation at the fetch address plus 2 and a second halfword read. `insn` is then {high halfword, low halfword}, even when the two halfwords lie on different pages.
- R6: With compressed mode off, the block makes exactly one translation and one 32-bit read (`mem_word` = 1), and `insn` equals `mem_rdata`.
- R7: A translation response with the fault flag set ends the fetch with `fault_cause` = 2, `insn` = 0 and `bad_vaddr` equal to the virtual address that was being translated (the fetch address or the fetch address plus 2). No memory read follows the fault.
- R8: `done` is a single-cycle pulse. `fetch_ready` is 0 from acceptance until `done`. A `fetch_valid` raised while the block is busy has no effect on the result of the fetch in progress. The block never raises `xl_req` and `mem_req` together. A successful fetch reports `fault_cause` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Fetch request, accepted when `fetch_ready` is 1 |
| fetch_ready | output | 1 | Block is idle and can accept a fetch |
| fetch_vaddr | input | VA_W | Virtual fetch address |
| cmp_en | input | 1 | Compressed (16-bit) instructions enabled |
| xl_req | output | 1 | Translation request, held until the response |
| xl_vaddr | output | VA_W | Virtual address to translate |
| xl_rsp_valid | input | 1 | Translation response pulse |
| xl_rsp_fault | input | 1 | Translation failed |
| xl_rsp_paddr | input | PA_W | Translated physical address |
| mem_req | output | 1 | Memory read request, held until the response |
| mem_addr | output | PA_W | Physical read address |
| mem_word | output | 1 | 1: 32-bit read, 0: halfword read in bits 15:0 |
| mem_rsp_valid | input | 1 | Memory read response pulse |
| mem_rdata | input | ILEN | Read data |
| done | output | 1 | Fetch completed (one-cycle pulse) |
| insn | output | ILEN | Fetched instruction bits, 0 on a fault |
| fault_cause | output | 2 | 0 none, 1 misaligned, 2 translation fault |
| bad_vaddr | output | VA_W | Faulting virtual address, 0 on success |

## Verification
`done` rises on the clock edge that consumes the last response, or on the accepting edge for a misaligned address. The bench responder answers every request one cycle after it is raised. This fixes the latencies in sampling points after acceptance at: 1 for a misalignment, 2 for a first-translation fault, 3 for a 16-bit or word-mode fetch, 4 for a second-translation fault and 5 for a full compressed-mode fetch. The bench samples `done` at every falling edge after acceptance and checks that the first sampling point where it is high matches the latency its reference function predicts. It then checks the result fields and the logged translation addresses at that same sampling point.

// File: rtl/ifx_pkg.sv
package ifx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_XL_LO = 3'd1,
    ST_RD_LO = 3'd2,
    ST_XL_HI = 3'd3,
    ST_RD_HI = 3'd4
  } ifx_state_e;

  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'd0,
    CAUSE_MISALIGN = 2'd1,
    CAUSE_ACCESS   = 2'd2
  } ifx_cause_e;
endpackage

// File: rtl/ifx_align_chk.sv
module ifx_align_chk #(
  parameter int VA_W = 32
) (
  input  logic [VA_W-1:0] vaddr,
  input  logic            cmp_en,
  output logic            misaligned
);
  // Halfword granularity with compressed mode, word granularity without.
  always_comb begin
    if (cmp_en) misaligned = vaddr[0];
    else        misaligned = |vaddr[1:0];
  end
endmodule

// File: rtl/ifx_assemble.sv
module ifx_assemble #(
  parameter int ILEN = 32
) (
  input  logic [ILEN/2-1:0] lo_hw,
  input  logic [ILEN/2-1:0] hi_hw,
  input  logic [ILEN/2-1:0] rd_hw,
  output logic              rd_short,
  output logic [ILEN-1:0]   short_insn,
  output logic [ILEN-1:0]   long_insn
);
  localparam int HW = ILEN / 2;

  always_comb begin
    rd_short   = (rd_hw[1:0] != 2'b11);
    short_insn = {{HW{1'b0}}, rd_hw};
    long_insn  = {hi_hw, lo_hw};
  end
endmodule

// File: rtl/ifx_fetch.sv
module ifx_fetch
  import ifx_pkg::*;
#(
  parameter int VA_W = 32,
  parameter int PA_W = 32,
  parameter int ILEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch_valid,
  output logic            fetch_ready,
  input  logic [VA_W-1:0] fetch_vaddr,
  input  logic            cmp_en,
  output logic            xl_req,
  output logic [VA_W-1:0] xl_vaddr,
  input  logic            xl_rsp_valid,
  input  logic            xl_rsp_fault,
  input  logic [PA_W-1:0] xl_rsp_paddr,
  output logic            mem_req,
  output logic [PA_W-1:0] mem_addr,
  output logic            mem_word,
  input  logic            mem_rsp_valid,
  input  logic [ILEN-1:0] mem_rdata,
  output logic            done,
  output logic [ILEN-1:0] insn,
  output logic [1:0]      fault_cause,
  output logic [VA_W-1:0] bad_vaddr
);
  localparam int HW       = ILEN / 2;
  localparam int HW_BYTES = HW / 8;

  ifx_state_e      state_q, state_d;
  logic [VA_W-1:0] vaddr_q, vaddr_d;
  logic            cmp_q, cmp_d;
  logic [PA_W-1:0] paddr_q, paddr_d;
  logic [HW-1:0]   lo_q, lo_d;
  logic            done_q, done_d;
  logic [ILEN-1:0] insn_q, insn_d;
  ifx_cause_e      cause_q, cause_d;
  logic [VA_W-1:0] bad_q, bad_d;

  logic            misaligned;
  logic            rd_short;
  logic [ILEN-1:0] short_insn, long_insn;

  ifx_align_chk #(.VA_W(VA_W)) u_align (
    .vaddr      (fetch_vaddr),
    .cmp_en     (cmp_en),
    .misaligned (misaligned)
  );

  ifx_assemble #(.ILEN(ILEN)) u_asm (
    .lo_hw      (lo_q),
    .hi_hw      (mem_rdata[HW-1:0]),
    .rd_hw      (mem_rdata[HW-1:0]),
    .rd_short   (rd_short),
    .short_insn (short_insn),
    .long_insn  (long_insn)
  );

  assign fetch_ready = (state_q == ST_IDLE);
  assign xl_req      = (state_q == ST_XL_LO) || (state_q == ST_XL_HI);
  assign xl_vaddr    = (state_q == ST_XL_HI) ? vaddr_q + VA_W'(HW_BYTES) : vaddr_q;
  assign mem_req     = (state_q == ST_RD_LO) || (state_q == ST_RD_HI);
  assign mem_addr    = paddr_q;
  assign mem_word    = !cmp_q;
  assign done        = done_q;
  assign insn        = insn_q;
  assign fault_cause = cause_q;
  assign bad_vaddr   = bad_q;

  always_comb begin
    state_d = state_q;
    vaddr_d = vaddr_q;
    cmp_d   = cmp_q;
    paddr_d = paddr_q;
    lo_d    = lo_q;
    done_d  = 1'b0;
    insn_d  = insn_q;
    cause_d = cause_q;
    bad_d   = bad_q;
    unique case (state_q)
      ST_IDLE: begin
        if (fetch_valid) begin
          vaddr_d = fetch_vaddr;
          cmp_d   = cmp_en;
          if (misaligned) begin
            done_d  = 1'b1;
            insn_d  = '0;
            cause_d = CAUSE_MISALIGN;
            bad_d   = fetch_vaddr;
          end else begin
            state_d = ST_XL_LO;
          end
        end
      end
      ST_XL_LO, ST_XL_HI: begin
        if (xl_rsp_valid) begin
          if (xl_rsp_fault) begin
            done_d  = 1'b1;
            insn_d  = '0;
            cause_d = CAUSE_ACCESS;
            bad_d   = xl_vaddr;
            state_d = ST_IDLE;
          end else begin
            paddr_d = xl_rsp_paddr;
            state_d = (state_q == ST_XL_LO) ? ST_RD_LO : ST_RD_HI;
          end
        end
      end
      ST_RD_LO: begin
        if (mem_rsp_valid) begin
          if (!cmp_q || rd_short) begin
            done_d  = 1'b1;
            insn_d  = cmp_q ? short_insn : mem_rdata;
            cause_d = CAUSE_NONE;
            bad_d   = '0;
            state_d = ST_IDLE;
          end else begin
            lo_d    = mem_rdata[HW-1:0];
            state_d = ST_XL_HI;
          end
        end
      end
      ST_RD_HI: begin
        if (mem_rsp_valid) begin
          done_d  = 1'b1;
          insn_d  = long_insn;
          cause_d = CAUSE_NONE;
          bad_d   = '0;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      vaddr_q <= '0;
      cmp_q   <= 1'b0;
      paddr_q <= '0;
      lo_q    <= '0;
      done_q  <= 1'b0;
      insn_q  <= '0;
      cause_q <= CAUSE_NONE;
      bad_q   <= '0;
    end else begin
      state_q <= state_d;
      vaddr_q <= vaddr_d;
      cmp_q   <= cmp_d;
      paddr_q <= paddr_d;
      lo_q    <= lo_d;
      done_q  <= done_d;
      insn_q  <= insn_d;
      cause_q <= cause_d;
      bad_q   <= bad_d;
    end
  end
endmodule

// File: rtl/ifx_fetch_chk.sv
module ifx_fetch_chk #(
  parameter int VA_W = 32,
  parameter int ILEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fetch_valid,
  input logic            fetch_ready,
  input logic [VA_W-1:0] fetch_vaddr,
  input logic            cmp_en,
  input logic            xl_req,
  input logic            mem_req,
  input logic            mem_word,
  input logic            cmp_q,
  input logic            done,
  input logic [ILEN-1:0] insn,
  input logic [1:0]      fault_cause,
  input logic [VA_W-1:0] bad_vaddr
);
  localparam int HW = ILEN / 2;

  AST_MISALIGN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_ready && (cmp_en ? fetch_vaddr[0] : (fetch_vaddr[1:0] != 2'b00)))
    |=> (done && fault_cause == 2'd1 && bad_vaddr == $past(fetch_vaddr))); // R2

  AST_IDLE_NO_XL: assert property (@(posedge clk) disable iff (!rst_n)
    xl_req |-> !fetch_ready); // R8

  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    !(xl_req && mem_req)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_SHORT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cmp_q && fault_cause == 2'd0 && insn[1:0] != 2'b11) |-> (insn[ILEN-1:HW] == '0)); // R4

  AST_WORD_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_word == !cmp_q)); // R6

  AST_FAULT_ZERO_INSN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault_cause != 2'd0) |-> (insn == '0)); // R7
endmodule

bind ifx_fetch ifx_fetch_chk #(.VA_W(VA_W), .ILEN(ILEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fetch_valid (fetch_valid),
  .fetch_ready (fetch_ready),
  .fetch_vaddr (fetch_vaddr),
  .cmp_en      (cmp_en),
  .xl_req      (xl_req),
  .mem_req     (mem_req),
  .mem_word    (mem_word),
  .cmp_q       (cmp_q),
  .done        (done),
  .insn        (insn),
  .fault_cause (fault_cause),
  .bad_vaddr   (bad_vaddr)
);

// File: tb/ifx_fetch_tb_top.sv
module ifx_fetch_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_valid;
  logic        fetch_ready;
  logic [31:0] fetch_vaddr;
  logic        cmp_en;
  logic        xl_req;
  logic [31:0] xl_vaddr;
  logic        xl_rsp_valid;
  logic        xl_rsp_fault;
  logic [31:0] xl_rsp_paddr;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_word;
  logic        mem_rsp_valid;
  logic [31:0] mem_rdata;
  logic        done;
  logic [31:0] insn;
  logic [1:0]  fault_cause;
  logic [31:0] bad_vaddr;

  int checks = 0;
  int errors = 0;
  int force_mode = 0;  // 0 raw, 1 all halfwords short, 2 all halfwords long
  int xl_cnt, mem_cnt, mem_word_cnt;
  logic [31:0] xl_log [2];

  always #4 clk = ~clk;

  ifx_fetch dut_i (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .fetch_vaddr(fetch_vaddr), .cmp_en(cmp_en),
    .xl_req(xl_req), .xl_vaddr(xl_vaddr),
    .xl_rsp_valid(xl_rsp_valid), .xl_rsp_fault(xl_rsp_fault), .xl_rsp_paddr(xl_rsp_paddr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_word(mem_word),
    .mem_rsp_valid(mem_rsp_valid), .mem_rdata(mem_rdata),
    .done(done), .insn(insn), .fault_cause(fault_cause), .bad_vaddr(bad_vaddr)
  );

  function automatic bit pg_fault(input logic [31:0] va);
    return va[15:12] == 4'hF;
  endfunction

  function automatic logic [31:0] xlate(input logic [31:0] va);
    return {va[31:12] ^ 20'h5A5A3, va[11:0]};
  endfunction

  function automatic logic [15:0] hw_at(input logic [31:0] pa);
    logic [15:0] h;
    h = (pa[15:0] * 16'h9E37) ^ pa[31:16] ^ 16'h1234;
    if (force_mode == 1) h[0] = 1'b0;
    if (force_mode == 2) h[1:0] = 2'b11;
    return h;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Responder: answers each held request one cycle later.
  initial begin
    xl_rsp_valid = 0; xl_rsp_fault = 0; xl_rsp_paddr = '0;
    mem_rsp_valid = 0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (xl_req && !xl_rsp_valid) begin
        xl_rsp_valid = 1;
        xl_rsp_fault = pg_fault(xl_vaddr);
        xl_rsp_paddr = xlate(xl_vaddr);
        if (xl_cnt < 2) xl_log[xl_cnt] = xl_vaddr;
        xl_cnt++;
      end else begin
        xl_rsp_valid = 0;
      end
      if (mem_req && !mem_rsp_valid) begin
        mem_rsp_valid = 1;
        mem_cnt++;
        if (mem_word) begin
          mem_word_cnt++;
          mem_rdata = {hw_at(mem_addr + 32'd2), hw_at(mem_addr)};
        end else begin
          mem_rdata = {16'hDEAD, hw_at(mem_addr)};
        end
      end else begin
        mem_rsp_valid = 0;
      end
    end
  end

  task automatic do_fetch(input logic [31:0] va, input logic cmp, input bit busy_poke);
    int lat, nxl, nmem, got;
    logic [31:0] e_insn, e_bad, pa, pa2, va2;
    logic [1:0] e_cause;
    logic [15:0] lo;
    string rq;
    va2 = va + 32'd2;
    pa = xlate(va);
    pa2 = xlate(va2);
    nmem = 0;
    if (cmp ? va[0] : (va[1:0] != 2'b00)) begin
      lat = 1; e_cause = 2'd1; e_bad = va; e_insn = 0; nxl = 0; rq = "R2";
    end else if (pg_fault(va)) begin
      lat = 2; e_cause = 2'd2; e_bad = va; e_insn = 0; nxl = 1; rq = "R7";
    end else if (!cmp) begin
      lat = 3; e_cause = 0; e_bad = 0; e_insn = {hw_at(pa + 32'd2), hw_at(pa)}; nxl = 1; nmem = 1; rq = "R6";
    end else begin
      lo = hw_at(pa);
      if (lo[1:0] != 2'b11) begin
        lat = 3; e_cause = 0; e_bad = 0; e_insn = {16'h0, lo}; nxl = 1; nmem = 1; rq = "R4";
      end else if (pg_fault(va2)) begin
        lat = 4; e_cause = 2'd2; e_bad = va2; e_insn = 0; nxl = 2; nmem = 1; rq = "R7";
      end else begin
        lat = 5; e_cause = 0; e_bad = 0; e_insn = {hw_at(pa2), lo}; nxl = 2; nmem = 2; rq = "R5";
      end
    end
    @(negedge clk);
    check("R8 ready before fetch", {31'b0, fetch_ready}, 32'd1);
    xl_cnt = 0; mem_cnt = 0; mem_word_cnt = 0;
    fetch_valid = 1; fetch_vaddr = va; cmp_en = cmp;
    got = 0;
    for (int c = 1; c <= 8; c++) begin
      @(negedge clk);
      if (busy_poke && c < lat) begin
        fetch_vaddr = 32'h0000_0001; cmp_en = ~cmp;
      end else begin
        fetch_valid = 0;
      end
      if (c == 1 && lat > 1) check("R8 ready low while busy", {31'b0, fetch_ready}, 32'd0);
      if (done) begin got = c; fetch_valid = 0; break; end
    end
    fetch_valid = 0;
    check({rq, " latency"}, got, lat);
    check({rq, " insn"}, insn, e_insn);
    check({rq, " cause"}, {30'b0, fault_cause}, {30'b0, e_cause});
    check({rq, " bad_vaddr"}, bad_vaddr, e_bad);
    check({rq, " translations"}, xl_cnt, nxl);
    check({rq, " memory reads"}, mem_cnt, nmem);
    if (nxl >= 1) check("R3 first translation address", xl_log[0], va);
    if (nxl == 2) check("R5 second translation address", xl_log[1], va2);
    if (cmp) check("R3 halfword reads", mem_word_cnt, 0);
    else     check("R6 word reads", mem_word_cnt, nmem);
    @(negedge clk);
    check("R8 done single pulse", {31'b0, done}, 32'd0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; fetch_valid = 0; fetch_vaddr = 0; cmp_en = 0;
    xl_cnt = 0; mem_cnt = 0; mem_word_cnt = 0;
    repeat (3) @(negedge clk);
    check("R1 done in reset", {31'b0, done}, 0);
    check("R1 xl_req in reset", {31'b0, xl_req}, 0);
    check("R1 mem_req in reset", {31'b0, mem_req}, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 ready after reset", {31'b0, fetch_ready}, 1);
    check("R1 done after reset", {31'b0, done}, 0);
    // directed corners
    force_mode = 2; do_fetch(32'h0000_1FFE, 1, 0);   // R5 page crossing
    force_mode = 2; do_fetch(32'h0000_EFFE, 1, 0);   // R7 high halfword fault
    force_mode = 1; do_fetch(32'h0000_2346, 1, 0);   // R4 short
    force_mode = 0; do_fetch(32'h0000_F000, 1, 0);   // R7 low fault
    force_mode = 0; do_fetch(32'h0000_3001, 1, 0);   // R2
    force_mode = 0; do_fetch(32'h0000_3002, 0, 0);   // R2 word mode
    force_mode = 0; do_fetch(32'h0000_3004, 0, 1);   // R6 with busy poke R8
    force_mode = 2; do_fetch(32'h0000_4FFE, 1, 1);   // R5 with busy poke R8
    for (int i = 0; i < 300; i++) begin
      logic [31:0] va;
      va = {16'h0, 16'($urandom)};
      if ($urandom_range(0, 3) != 0) va[0] = 1'b0;
      force_mode = $urandom_range(0, 2);
      do_fetch(va, 1'($urandom), 1'($urandom));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule